// File: doc/BRIEF.md
# Bit-Serial CRC Engine

This block computes a cyclic redundancy check one bit per clock. Each accepted message bit is folded into a Galois-form shift register. After the last bit, the register holds the remainder of M(x)·x^n divided by the generator G(x), where n is the CRC width. A parameter selects one of three generators: 8-bit, 16-bit or 32-bit. The register width follows from that choice.

The same register serves both ends of a link. On the sending side, the remainder is read in parallel, or it is shifted out MSB-first over n clocks so it can be appended to the frame. On the receiving side, the whole frame, including its appended remainder, is fed through the register. A flag then reports whether the final contents equal the expected residue, which is zero for this non-inverted form. A clear pulse empties the register before each frame. The clear pulse takes priority over shifting out, and shifting out takes priority over accepting data.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset, `crc_o` is all zeros and `crc_ok_o` is high (with the default residue of zero).
- R2: When `init_i` is high at a clock edge, the register is zero after that edge, whatever `shift_i` and `bit_vld_i` do.
- R3: When `bit_vld_i` is high and neither `init_i` nor `shift_i` is high, let f be the register's MSB XOR `bit_i`. The register moves one place toward the MSB with 0 entering bit 0, and it is then XORed with the generator's low coefficients if f is 1.
- R4: `POLY_SEL` 0 gives an 8-bit register with low coefficients 0x07. `POLY_SEL` 1 gives 16 bits with 0x1021. `POLY_SEL` 2 gives 32 bits with 0x04C11DB7. The x^n term is always implied.
- R5: After clearing and feeding a message MSB-first, `crc_o` equals M(x)·x^n mod G(x).
- R6: When `shift_i` is high and `init_i` is low, the register moves toward the MSB with 0 entering bit 0, and `bit_vld_i` is ignored. Because `crc_bit_o` always shows the register MSB, n such clocks present the remainder MSB-first and leave the register zero.
- R7: When none of `init_i`, `shift_i` or `bit_vld_i` is high, the register and `crc_bit_o` keep their values.
- R8: `crc_ok_o` is high exactly when the register equals the `RESIDUE` parameter. A frame followed by its own remainder, MSB-first, drives it high.
- R9: A frame with any single bit inverted, followed by the remainder of the unaltered frame, leaves `crc_ok_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Clears the register before a frame |
| bit_vld_i | input | 1 | Marks `bit_i` as a message bit this clock |
| bit_i | input | 1 | Serial message bit, MSB first |
| shift_i | input | 1 | Shifts the remainder out toward the MSB |
| crc_o | output | W | Register contents (remainder) |
| crc_bit_o | output | 1 | Serial remainder bit (register MSB) |
| crc_ok_o | output | 1 | Register equals the expected residue |

## Verification
All 256 one-byte messages run through the 8-bit, 16-bit and 32-bit variants side by side, followed by random frames of up to 64 bits. Each result is compared with an arithmetic long-division model. A design with a misplaced tap or a reversed bit order gives a wrong remainder for most of these messages. A design that shifts out LSB-first or fills bit 0 with a nonzero value gives a wrong appended value, and the registered residue is then not zero. Every frame is also replayed with one inverted bit, which catches a compare that ignores some stages. Directed cases cover the control corners: a clear pulse that arrives together with data and shift, a shift that arrives together with valid data, and idle clocks during which the state must hold.

// File: rtl/crc_serial_pkg.sv
`timescale 1ns/1ps
package crc_serial_pkg;

   // Operation applied to the shift register on a clock edge
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_CLEAR = 2'd1,
      OP_SHIFT = 2'd2,
      OP_ACCUM = 2'd3
   } crc_op_e;

   // Register width for each generator choice
   function automatic int unsigned crc_width(int unsigned sel);
      case (sel)
         0:       return 8;
         1:       return 16;
         default: return 32;
      endcase
   endfunction

   // Generator coefficients below the implied x^n term
   function automatic logic [31:0] crc_taps(int unsigned sel);
      case (sel)
         0:       return 32'h0000_0007;
         1:       return 32'h0000_1021;
         default: return 32'h04C1_1DB7;
      endcase
   endfunction

endpackage

// File: rtl/crc_op_decode.sv
`timescale 1ns/1ps
module crc_op_decode
   import crc_serial_pkg::*;
(
   input  logic    init_i,
   input  logic    shift_i,
   input  logic    vld_i,
   output crc_op_e op_o
);

   // Fixed priority: clear, then shift-out, then accumulate
   always_comb begin
      if (init_i)       op_o = OP_CLEAR;
      else if (shift_i) op_o = OP_SHIFT;
      else if (vld_i)   op_o = OP_ACCUM;
      else              op_o = OP_HOLD;
   end

endmodule

// File: rtl/crc_galois_core.sv
`timescale 1ns/1ps
module crc_galois_core
   import crc_serial_pkg::*;
#(
   parameter int unsigned W    = 8,
   parameter logic [W-1:0] TAPS = '0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  crc_op_e      op_i,
   input  logic         bit_i,
   output logic [W-1:0] state_o
);

   logic [W-1:0] state_q;
   logic [W-1:0] state_d;
   logic [W-1:0] moved;
   logic [W-1:0] divided;
   logic         fb;

   assign fb    = state_q[W-1] ^ bit_i;
   assign moved = {state_q[W-2:0], 1'b0};

   // One XOR per generator tap, a plain wire elsewhere
   generate
      for (genvar i = 0; i < W; i++) begin : g_stage
         if (TAPS[i]) begin : g_tap
            assign divided[i] = moved[i] ^ fb;
         end else begin : g_plain
            assign divided[i] = moved[i];
         end
      end
   endgenerate

   always_comb begin
      case (op_i)
         OP_CLEAR: state_d = '0;
         OP_SHIFT: state_d = moved;
         OP_ACCUM: state_d = divided;
         default:  state_d = state_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/crc_residue_cmp.sv
`timescale 1ns/1ps
module crc_residue_cmp #(
   parameter int unsigned  W       = 8,
   parameter logic [W-1:0] RESIDUE = '0
)(
   input  logic [W-1:0] state_i,
   output logic         match_o
);

   assign match_o = (state_i == RESIDUE);

endmodule

// File: rtl/crc_serial_engine.sv
`timescale 1ns/1ps
module crc_serial_engine
   import crc_serial_pkg::*;
#(
   parameter  int unsigned POLY_SEL = 2,
   parameter  logic [31:0] RESIDUE  = 32'h0,
   localparam int unsigned W        = crc_width(POLY_SEL),
   localparam logic [31:0] TAPS_ALL = crc_taps(POLY_SEL)
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init_i,
   input  logic         bit_vld_i,
   input  logic         bit_i,
   input  logic         shift_i,
   output logic [W-1:0] crc_o,
   output logic         crc_bit_o,
   output logic         crc_ok_o
);

   localparam logic [W-1:0] TAPS = TAPS_ALL[W-1:0];
   localparam logic [W-1:0] EXP  = RESIDUE[W-1:0];

   generate
      if (POLY_SEL > 2) begin : g_bad_sel
         $error("crc_serial_engine: POLY_SEL must be 0, 1 or 2");
      end
      if (TAPS[0] != 1'b1) begin : g_bad_taps
         $error("crc_serial_engine: generator needs an x^0 term");
      end
   endgenerate

   crc_op_e op;

   crc_op_decode u_dec (
      .init_i  (init_i),
      .shift_i (shift_i),
      .vld_i   (bit_vld_i),
      .op_o    (op)
   );

   crc_galois_core #(.W(W), .TAPS(TAPS)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (op),
      .bit_i   (bit_i),
      .state_o (crc_o)
   );

   crc_residue_cmp #(.W(W), .RESIDUE(EXP)) u_cmp (
      .state_i (crc_o),
      .match_o (crc_ok_o)
   );

   assign crc_bit_o = crc_o[W-1];

endmodule

// File: rtl/crc_serial_engine_chk.sv
`timescale 1ns/1ps
module crc_serial_engine_chk #(
   parameter int unsigned W       = 8,
   parameter logic [31:0] RESIDUE = 32'h0
)(
   input logic         clk,
   input logic         rst_n,
   input logic         init_i,
   input logic         bit_vld_i,
   input logic         bit_i,
   input logic         shift_i,
   input logic [W-1:0] crc_o,
   input logic         crc_bit_o,
   input logic         crc_ok_o
);

   localparam bit EXP_ZERO = (RESIDUE[W-1:0] == '0);

   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (crc_o == '0));

   p_step_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld_i && !shift_i && !init_i) |=> (crc_o[0] == $past(crc_o[W-1] ^ bit_i)));

   p_shift_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !init_i) |=> (crc_o[0] == 1'b0 && crc_o[W-1:1] == $past(crc_o[W-2:0])));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && !shift_i && !bit_vld_i) |=> $stable(crc_o));

   p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && !shift_i && !bit_vld_i) |=> $stable(crc_bit_o));

   p_ok_after_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (crc_ok_o == EXP_ZERO));

endmodule

bind crc_serial_engine crc_serial_engine_chk #(.W(W), .RESIDUE(RESIDUE)) u_chk (.*);

// File: tb/crc_serial_engine_tb_top.sv
`timescale 1ns/1ps
module crc_serial_engine_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init = 1'b0;
   logic [2:0]  vld = '0;
   logic [2:0]  bits = '0;
   logic [2:0]  shf = '0;
   logic [7:0]  c8;
   logic [15:0] c16;
   logic [31:0] c32;
   logic [2:0]  ob;
   logic [2:0]  ok;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   crc_serial_engine #(.POLY_SEL(0)) dut8_i (
      .clk(clk), .rst_n(rst_n), .init_i(init), .bit_vld_i(vld[0]), .bit_i(bits[0]),
      .shift_i(shf[0]), .crc_o(c8), .crc_bit_o(ob[0]), .crc_ok_o(ok[0]));

   crc_serial_engine #(.POLY_SEL(1)) dut16_i (
      .clk(clk), .rst_n(rst_n), .init_i(init), .bit_vld_i(vld[1]), .bit_i(bits[1]),
      .shift_i(shf[1]), .crc_o(c16), .crc_bit_o(ob[1]), .crc_ok_o(ok[1]));

   crc_serial_engine #(.POLY_SEL(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .init_i(init), .bit_vld_i(vld[2]), .bit_i(bits[2]),
      .shift_i(shf[2]), .crc_o(c32), .crc_bit_o(ob[2]), .crc_ok_o(ok[2]));

   // Arithmetic long division over GF(2), MSB first
   function automatic logic [31:0] ref_crc(input logic [63:0] m, input int len,
                                           input int w, input logic [31:0] p);
      logic [31:0] r = '0;
      logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
      logic        fb;
      for (int i = len - 1; i >= 0; i--) begin
         fb = r[w-1] ^ m[i];
         r  = ((r << 1) & mask) ^ (fb ? p : 32'h0);
      end
      return r;
   endfunction

   task automatic chk(input bit cond, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!cond) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_init();
      init = 1'b1; vld = '0; shf = '0;
      step();
      init = 1'b0;
   endtask

   task automatic feed_msg(input logic [63:0] m, input int len, input int flip);
      for (int i = len - 1; i >= 0; i--) begin
         bits = {3{m[i] ^ (i == flip)}};
         vld  = 3'b111;
         step();
      end
      vld = '0; bits = '0;
   endtask

   task automatic feed_crc(input logic [7:0] r8, input logic [15:0] r16, input logic [31:0] r32);
      for (int k = 0; k < 32; k++) begin
         vld[0]  = (k < 8);
         vld[1]  = (k < 16);
         vld[2]  = 1'b1;
         bits[0] = (k < 8)  ? r8[7-k]   : 1'b0;
         bits[1] = (k < 16) ? r16[15-k] : 1'b0;
         bits[2] = r32[31-k];
         step();
      end
      vld = '0; bits = '0;
   endtask

   task automatic shift_out(output logic [7:0] s8, output logic [15:0] s16, output logic [31:0] s32);
      s8 = '0; s16 = '0; s32 = '0;
      for (int k = 0; k < 32; k++) begin
         shf = {1'b1, k < 16, k < 8};
         if (k < 8)  s8[7-k]   = ob[0];
         if (k < 16) s16[15-k] = ob[1];
         s32[31-k] = ob[2];
         step();
      end
      shf = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [63:0] m;
      int          len;
      logic [7:0]  e8, s8;
      logic [15:0] e16, s16;
      logic [31:0] e32, s32, snap;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1: reset state
      chk(c8 == 8'h0 && c16 == 16'h0 && c32 == 32'h0, "R1 crc zero", c32, 32'h0);
      chk(ok == 3'b111, "R1 ok high", {29'h0, ok}, 32'h7);

      // R3/R4: single one bit from zero loads the generator coefficients
      do_init();
      bits = 3'b111; vld = 3'b111; step(); vld = '0;
      chk(c8 == 8'h07, "R3 R4 8-bit step", {24'h0, c8}, 32'h07);
      chk(c16 == 16'h1021, "R3 R4 16-bit step", {16'h0, c16}, 32'h1021);
      chk(c32 == 32'h04C11DB7, "R3 R4 32-bit step", c32, 32'h04C11DB7);

      // R6: shift wins over valid data
      snap = c32;
      shf = 3'b111; vld = 3'b111; bits = 3'b111; step(); shf = '0; vld = '0;
      chk(c32 == (snap << 1), "R6 shift over valid", c32, snap << 1);
      chk(c8 == 8'h0E, "R6 shift over valid 8", {24'h0, c8}, 32'h0E);

      // R7: idle clocks hold state and serial bit
      snap = c32;
      s8 = {7'h0, ob[2]};
      repeat (5) step();
      chk(c32 == snap, "R7 hold", c32, snap);
      chk(ob[2] == s8[0], "R7 serial hold", {31'h0, ob[2]}, {31'h0, s8[0]});

      // R2: clear wins over shift and valid
      init = 1'b1; shf = 3'b111; vld = 3'b111; bits = 3'b111; step();
      init = 1'b0; shf = '0; vld = '0;
      chk(c8 == 8'h0 && c16 == 16'h0 && c32 == 32'h0, "R2 clear priority", c32, 32'h0);

      // Sweep: every byte, then random longer frames
      for (int v = 0; v < 256 + 24; v++) begin
         if (v < 256) begin
            m = 64'(v); len = 8;
         end else begin
            m = {$urandom, $urandom}; len = 9 + int'($urandom % 56);
         end
         e8  = ref_crc(m, len, 8,  32'h07)[7:0];
         e16 = ref_crc(m, len, 16, 32'h1021)[15:0];
         e32 = ref_crc(m, len, 32, 32'h04C11DB7);

         do_init();
         feed_msg(m, len, -1);
         chk(c8 == e8,   "R5 remainder 8",  {24'h0, c8}, {24'h0, e8});
         chk(c16 == e16, "R5 remainder 16", {16'h0, c16}, {16'h0, e16});
         chk(c32 == e32, "R5 R4 remainder 32", c32, e32);

         shift_out(s8, s16, s32);
         chk(s8 == e8 && s16 == e16 && s32 == e32, "R6 serial remainder", s32, e32);
         chk(c8 == 8'h0 && c16 == 16'h0 && c32 == 32'h0, "R6 zero after shift", c32, 32'h0);

         do_init();
         feed_msg(m, len, -1);
         feed_crc(e8, e16, e32);
         chk(ok == 3'b111, "R8 good frame", {29'h0, ok}, 32'h7);

         do_init();
         feed_msg(m, len, v % len);
         feed_crc(e8, e16, e32);
         chk(ok == 3'b000, "R9 flipped frame", {29'h0, ok}, 32'h0);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule